// File: doc/BRIEF.md
# Data Cache Maintenance Controller

This block is the maintenance side of a small four-way set-associative write-back data cache. It owns the valid, dirty and tag state of every line and accepts commands over a simple auxiliary register port (address, write data, write enable, read data, ready). Commands cover the whole cache or one line, and either invalidate or write back. Dirty lines leave through a request/acknowledge write-back port, one line at a time. The normal lookup path of the cache installs lines through a fill port and queries residency through a lookup port; both are included only so that the state this block maintains can be set and observed.

A whole-cache command walks every line in ascending set order, and within a set in ascending way order. A single-line command takes its set index from the virtual address written to the command register and its tag from a previously written physical-tag register. A control bit picks whether invalidation discards dirty data or writes it back first. A read-only status bit shows that a write-back operation is still running. The finite-state machine has four states: IDLE (waiting for a command), PROBE (one cycle to resolve the way of a line command), SWEEP (visit one line of a whole-cache walk per cycle) and WRITEBACK (hold a write-back request until it is acknowledged). The transitions are: IDLE to SWEEP on a whole-cache command, and IDLE to PROBE on a line command. PROBE goes to WRITEBACK when the matched line needs a write-back, and to IDLE in every other case. SWEEP goes to WRITEBACK when the current line needs a write-back, stays in SWEEP while more lines remain, and goes to IDLE after the last line. WRITEBACK stays put until the acknowledge arrives, then goes back to SWEEP while a walk has lines left and to IDLE otherwise.

Top module: `dcache_maint`

## Requirements
- R1: Register addresses are: control 0x048, physical tag 0x05C, whole-cache invalidate 0x047, whole-cache write-back 0x04B, line invalidate 0x04A, line write-back 0x04C. A write takes effect only in a cycle where aux_ready is 1. The physical-tag register keeps write-data bits [31:8] and reads back with bits [7:0] zero. Reads of the command registers return 0.
- R2: Control bit 0 drives cache_disable and bit 6 selects the invalidate mode. Both are writable, read back at the same positions, and reset to 0.
- R3: Writing a value with bit 0 set to the whole-cache write-back register writes back every valid dirty line, in ascending set and then ascending way order. Every line that was valid stays valid and becomes clean.
- R4: A whole-cache invalidate with mode bit 0 clear leaves every line invalid and issues no write-back.
- R5: A whole-cache invalidate with mode bit 0 set writes back every valid dirty line, in walk order, and then leaves every line invalid.
- R6: A line write-back uses address bits [7:5] as the set index and the physical-tag register as the tag. It writes back only the matching way, and only when that way is dirty. The line stays valid and becomes clean; the other ways are untouched.
- R7: A line invalidate of a matching line clears it. When the mode bit is 1 and the line is dirty, the line is written back first. When the mode bit is 0, no write-back is issued.
- R8: A line command with no valid way whose tag matches is a no-op: aux_ready is low for exactly one cycle and no write-back is issued.
- R9: Control read bit 8 is 1 from the cycle after a write-back operation is accepted until its last write-back is acknowledged. It is 0 at all other times, including during a discard-only walk, and writes to it are ignored.
- R10: While any operation runs, aux_ready is 0 and register writes have no effect.
- R11: A write-back request holds its set, way and tag stable until it is acknowledged. The line stays dirty until that acknowledge arrives.
- R12: Line commands ignore address bits [4:0]. Successive line commands reuse the stored physical tag without rewriting it.
- R13: A whole-cache command written with bit 0 clear does nothing, and aux_ready stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| aux_addr | input | 12 | Register address |
| aux_wdata | input | 32 | Register write data |
| aux_we | input | 1 | Register write strobe |
| aux_ready | output | 1 | 1 when a register write will be accepted |
| aux_rdata | output | 32 | Register read data for aux_addr |
| cache_disable | output | 1 | Cache disable flag from the control register |
| fill_en | input | 1 | Install a line (from the lookup path) |
| fill_idx | input | 3 | Set of the line to install |
| fill_way | input | 2 | Way of the line to install |
| fill_tag | input | 24 | Tag of the installed line |
| fill_dirty | input | 1 | Dirty state of the installed line |
| lk_idx | input | 3 | Lookup set |
| lk_tag | input | 24 | Lookup tag |
| lk_hit | output | 1 | A valid way at lk_idx holds lk_tag |
| lk_dirty | output | 1 | The hitting way is dirty |
| wb_req | output | 1 | Write-back request |
| wb_idx | output | 3 | Set of the line being written back |
| wb_way | output | 2 | Way of the line being written back |
| wb_tag | output | 24 | Tag of the line being written back |
| wb_ack | input | 1 | Write-back acknowledge |

## Verification
On every cycle the assertions check the following. A pending write-back request holds its set, way and tag stable, and keeps its line dirty until the acknowledge. No request is raised while aux_ready is high. The status bit is only ever seen while the block is busy, and it is always seen while a request is pending. A control write lands in cache_disable on the next cycle. The directed scenarios are the only way to show the rest: the order and completeness of a walk's write-backs, the split between discard and write-back invalidation, tag matching and index extraction for line commands, the one-cycle no-op, and writes that are ignored while busy. Each of these is confirmed through the write-back log and through lookups after the command ends.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
    localparam int AUX_AW = 12;
    localparam int AUX_DW = 32;

    localparam logic [AUX_AW-1:0] REG_INV_ALL    = 12'h047;
    localparam logic [AUX_AW-1:0] REG_CTRL       = 12'h048;
    localparam logic [AUX_AW-1:0] REG_INV_LINE   = 12'h04A;
    localparam logic [AUX_AW-1:0] REG_FLUSH_ALL  = 12'h04B;
    localparam logic [AUX_AW-1:0] REG_FLUSH_LINE = 12'h04C;
    localparam logic [AUX_AW-1:0] REG_PTAG       = 12'h05C;

    localparam int CTRL_DIS_BIT  = 0;
    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_STAT_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PROBE,
        ST_SWEEP,
        ST_WRITEBACK
    } walk_state_t;
endpackage

// File: rtl/dcm_regs.sv
module dcm_regs
    import dcm_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int OFF_W = 5,
    parameter int TAG_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AUX_AW-1:0] aux_addr,
    input  logic [AUX_DW-1:0] aux_wdata,
    input  logic              aux_we,
    input  logic              ready,
    input  logic              stat_busy,
    output logic [AUX_DW-1:0] aux_rdata,
    output logic              ctl_disable,
    output logic              ctl_wbmode,
    output logic [TAG_W-1:0]  ptag,
    output logic              go_all,
    output logic              go_line,
    output logic              go_inv,
    output logic              go_wb,
    output logic [IDX_W-1:0]  go_idx
);
    logic wr;
    logic unused_wdata;

    assign wr           = aux_we && ready;
    assign unused_wdata = ^aux_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_disable <= 1'b0;
            ctl_wbmode  <= 1'b0;
            ptag        <= '0;
        end else if (wr) begin
            if (aux_addr == REG_CTRL) begin
                ctl_disable <= aux_wdata[CTRL_DIS_BIT];
                ctl_wbmode  <= aux_wdata[CTRL_MODE_BIT];
            end
            if (aux_addr == REG_PTAG)
                ptag <= aux_wdata[AUX_DW-1 -: TAG_W];
        end
    end

    always_comb begin
        go_all  = wr && aux_wdata[0] &&
                  ((aux_addr == REG_INV_ALL) || (aux_addr == REG_FLUSH_ALL));
        go_line = wr && ((aux_addr == REG_INV_LINE) || (aux_addr == REG_FLUSH_LINE));
        go_inv  = (aux_addr == REG_INV_ALL) || (aux_addr == REG_INV_LINE);
        go_wb   = go_inv ? ctl_wbmode : 1'b1;
        go_idx  = aux_wdata[OFF_W +: IDX_W];
    end

    always_comb begin
        aux_rdata = '0;
        case (aux_addr)
            REG_CTRL: begin
                aux_rdata[CTRL_DIS_BIT]  = ctl_disable;
                aux_rdata[CTRL_MODE_BIT] = ctl_wbmode;
                aux_rdata[CTRL_STAT_BIT] = stat_busy;
            end
            REG_PTAG: aux_rdata = {ptag, {(AUX_DW-TAG_W){1'b0}}};
            default:  aux_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dcm_tags.sv
module dcm_tags #(
    parameter int IDX_W = 3,
    parameter int WAY_W = 2,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [WAY_W-1:0] fill_way,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_dirty,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [WAY_W-1:0] upd_way,
    input  logic             upd_clr_valid,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [WAY_W-1:0] rd_way,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] m_idx,
    input  logic [TAG_W-1:0] m_tag,
    output logic             m_hit,
    output logic [WAY_W-1:0] m_way,
    output logic             m_dirty,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_dirty
);
    localparam int SETS = 1 << IDX_W;
    localparam int WAYS = 1 << WAY_W;

    logic [WAYS-1:0]  vld_q [SETS];
    logic [WAYS-1:0]  dty_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    logic [WAYS-1:0]  m_vec;
    logic [WAYS-1:0]  lk_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                dty_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
            end
        end else begin
            if (fill_en) begin
                vld_q[fill_idx][fill_way] <= 1'b1;
                dty_q[fill_idx][fill_way] <= fill_dirty;
                tag_q[fill_idx][fill_way] <= fill_tag;
            end
            if (upd_en) begin
                dty_q[upd_idx][upd_way] <= 1'b0;
                if (upd_clr_valid) vld_q[upd_idx][upd_way] <= 1'b0;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign m_vec[g]  = vld_q[m_idx][g]  && (tag_q[m_idx][g]  == m_tag);
            assign lk_vec[g] = vld_q[lk_idx][g] && (tag_q[lk_idx][g] == lk_tag);
        end
    endgenerate

    always_comb begin
        m_way = '0;
        for (int w = WAYS - 1; w >= 0; w--)
            if (m_vec[w]) m_way = WAY_W'(w);
        m_hit    = |m_vec;
        m_dirty  = m_hit && dty_q[m_idx][m_way];
        lk_hit   = |lk_vec;
        lk_dirty = |(lk_vec & dty_q[lk_idx]);
        rd_valid = vld_q[rd_idx][rd_way];
        rd_dirty = dty_q[rd_idx][rd_way];
        rd_tag   = tag_q[rd_idx][rd_way];
    end
endmodule

// File: rtl/dcm_walk.sv
module dcm_walk
    import dcm_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int WAY_W = 2,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_all,
    input  logic             go_line,
    input  logic             go_inv,
    input  logic             go_wb,
    input  logic [IDX_W-1:0] go_idx,
    input  logic [TAG_W-1:0] ptag,
    input  logic             rd_valid,
    input  logic             rd_dirty,
    input  logic [TAG_W-1:0] rd_tag,
    input  logic             m_hit,
    input  logic [WAY_W-1:0] m_way,
    input  logic             m_dirty,
    input  logic             wb_ack,
    output logic             ready,
    output logic             stat_busy,
    output logic [IDX_W-1:0] rd_idx,
    output logic [WAY_W-1:0] rd_way,
    output logic [IDX_W-1:0] m_idx,
    output logic [TAG_W-1:0] m_tag,
    output logic             upd_en,
    output logic [IDX_W-1:0] upd_idx,
    output logic [WAY_W-1:0] upd_way,
    output logic             upd_clr_valid,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_idx,
    output logic [WAY_W-1:0] wb_way,
    output logic [TAG_W-1:0] wb_tag
);
    localparam int CNT_W = IDX_W + WAY_W;

    walk_state_t      state_q, state_d;
    logic             op_inv_q, op_wb_q, op_all_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] ln_idx_q, wb_idx_q;
    logic [TAG_W-1:0] ln_tag_q, wb_tag_q;
    logic [WAY_W-1:0] wb_way_q;
    logic             last, need_wb_sweep, need_wb_probe;

    assign rd_idx        = cnt_q[CNT_W-1 -: IDX_W];
    assign rd_way        = cnt_q[WAY_W-1:0];
    assign m_idx         = ln_idx_q;
    assign m_tag         = ln_tag_q;
    assign last          = (cnt_q == {CNT_W{1'b1}});
    assign need_wb_sweep = rd_valid && rd_dirty && op_wb_q;
    assign need_wb_probe = m_hit && m_dirty && op_wb_q;
    assign wb_idx        = wb_idx_q;
    assign wb_way        = wb_way_q;
    assign wb_tag        = wb_tag_q;

    // state register and per-state datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_inv_q <= 1'b0;
            op_wb_q  <= 1'b0;
            op_all_q <= 1'b0;
            cnt_q    <= '0;
            ln_idx_q <= '0;
            ln_tag_q <= '0;
            wb_idx_q <= '0;
            wb_way_q <= '0;
            wb_tag_q <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_IDLE: if (go_all || go_line) begin
                    op_inv_q <= go_inv;
                    op_wb_q  <= go_wb;
                    op_all_q <= go_all;
                    cnt_q    <= '0;
                    ln_idx_q <= go_idx;
                    ln_tag_q <= ptag;
                end
                ST_PROBE: if (need_wb_probe) begin
                    wb_idx_q <= ln_idx_q;
                    wb_way_q <= m_way;
                    wb_tag_q <= ln_tag_q;
                end
                ST_SWEEP: begin
                    if (need_wb_sweep) begin
                        wb_idx_q <= rd_idx;
                        wb_way_q <= rd_way;
                        wb_tag_q <= rd_tag;
                    end else if (!last) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_WRITEBACK: if (wb_ack && op_all_q && !last) cnt_q <= cnt_q + 1'b1;
            endcase
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (go_all) state_d = ST_SWEEP;
                          else if (go_line) state_d = ST_PROBE;
            ST_PROBE:     state_d = need_wb_probe ? ST_WRITEBACK : ST_IDLE;
            ST_SWEEP:     if (need_wb_sweep) state_d = ST_WRITEBACK;
                          else if (last) state_d = ST_IDLE;
            ST_WRITEBACK: if (wb_ack) state_d = (op_all_q && !last) ? ST_SWEEP : ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready         = (state_q == ST_IDLE);
        stat_busy     = (state_q != ST_IDLE) && op_wb_q;
        wb_req        = (state_q == ST_WRITEBACK);
        upd_en        = 1'b0;
        upd_idx       = rd_idx;
        upd_way       = rd_way;
        upd_clr_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_PROBE: if (m_hit && op_inv_q && !need_wb_probe) begin
                upd_en        = 1'b1;
                upd_idx       = ln_idx_q;
                upd_way       = m_way;
                upd_clr_valid = 1'b1;
            end
            ST_SWEEP: if (op_inv_q && !need_wb_sweep) begin
                upd_en        = 1'b1;
                upd_clr_valid = 1'b1;
            end
            ST_WRITEBACK: if (wb_ack) begin
                upd_en        = 1'b1;
                upd_idx       = wb_idx_q;
                upd_way       = wb_way_q;
                upd_clr_valid = op_inv_q;
            end
        endcase
    end
endmodule

// File: rtl/dcache_maint.sv
module dcache_maint
    import dcm_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic [11:0]                                      aux_addr,
    input  logic [31:0]                                      aux_wdata,
    input  logic                                             aux_we,
    output logic                                             aux_ready,
    output logic [31:0]                                      aux_rdata,
    output logic                                             cache_disable,
    input  logic                                             fill_en,
    input  logic [$clog2(SETS)-1:0]                          fill_idx,
    input  logic [$clog2(WAYS)-1:0]                          fill_way,
    input  logic [31-$clog2(SETS)-$clog2(LINE_BYTES):0]      fill_tag,
    input  logic                                             fill_dirty,
    input  logic [$clog2(SETS)-1:0]                          lk_idx,
    input  logic [31-$clog2(SETS)-$clog2(LINE_BYTES):0]      lk_tag,
    output logic                                             lk_hit,
    output logic                                             lk_dirty,
    output logic                                             wb_req,
    output logic [$clog2(SETS)-1:0]                          wb_idx,
    output logic [$clog2(WAYS)-1:0]                          wb_way,
    output logic [31-$clog2(SETS)-$clog2(LINE_BYTES):0]      wb_tag,
    input  logic                                             wb_ack
);
    localparam int IDX_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int TAG_W = AUX_DW - IDX_W - OFF_W;

    logic             stat_busy, ctl_wbmode;
    logic [TAG_W-1:0] ptag;
    logic             go_all, go_line, go_inv, go_wb;
    logic [IDX_W-1:0] go_idx, rd_idx, m_idx, upd_idx;
    logic [WAY_W-1:0] rd_way, m_way, upd_way;
    logic             rd_valid, rd_dirty, m_hit, m_dirty, upd_en, upd_clr_valid;
    logic [TAG_W-1:0] rd_tag, m_tag;

    dcm_regs #(.IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
        .aux_we(aux_we), .ready(aux_ready), .stat_busy(stat_busy),
        .aux_rdata(aux_rdata), .ctl_disable(cache_disable), .ctl_wbmode(ctl_wbmode),
        .ptag(ptag), .go_all(go_all), .go_line(go_line), .go_inv(go_inv),
        .go_wb(go_wb), .go_idx(go_idx)
    );

    dcm_tags #(.IDX_W(IDX_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_dirty(fill_dirty),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_way(upd_way), .upd_clr_valid(upd_clr_valid),
        .rd_idx(rd_idx), .rd_way(rd_way), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .m_idx(m_idx), .m_tag(m_tag), .m_hit(m_hit), .m_way(m_way), .m_dirty(m_dirty),
        .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_dirty(lk_dirty)
    );

    dcm_walk #(.IDX_W(IDX_W), .WAY_W(WAY_W), .TAG_W(TAG_W)) u_walk (
        .clk(clk), .rst_n(rst_n),
        .go_all(go_all), .go_line(go_line), .go_inv(go_inv), .go_wb(go_wb),
        .go_idx(go_idx), .ptag(ptag),
        .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
        .m_hit(m_hit), .m_way(m_way), .m_dirty(m_dirty), .wb_ack(wb_ack),
        .ready(aux_ready), .stat_busy(stat_busy),
        .rd_idx(rd_idx), .rd_way(rd_way), .m_idx(m_idx), .m_tag(m_tag),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_way(upd_way), .upd_clr_valid(upd_clr_valid),
        .wb_req(wb_req), .wb_idx(wb_idx), .wb_way(wb_way), .wb_tag(wb_tag)
    );
endmodule

// File: rtl/dcache_maint_chk.sv
module dcache_maint_chk
    import dcm_pkg::*;
#(
    parameter int SETS       = 8,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 32
) (
    input logic                                        clk,
    input logic                                        rst_n,
    input logic [11:0]                                 aux_addr,
    input logic [31:0]                                 aux_wdata,
    input logic                                        aux_we,
    input logic                                        aux_ready,
    input logic [31:0]                                 aux_rdata,
    input logic                                        cache_disable,
    input logic [$clog2(SETS)-1:0]                     lk_idx,
    input logic [31-$clog2(SETS)-$clog2(LINE_BYTES):0] lk_tag,
    input logic                                        lk_hit,
    input logic                                        lk_dirty,
    input logic                                        wb_req,
    input logic [$clog2(SETS)-1:0]                     wb_idx,
    input logic [$clog2(WAYS)-1:0]                     wb_way,
    input logic [31-$clog2(SETS)-$clog2(LINE_BYTES):0] wb_tag,
    input logic                                        wb_ack
);
    assert_wb_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_idx) && $stable(wb_way) && $stable(wb_tag));

    assert_dirty_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack && lk_idx == wb_idx && lk_tag == wb_tag |-> lk_hit && lk_dirty);

    assert_no_req_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !aux_ready);

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        aux_we && aux_ready && aux_addr == REG_CTRL |=> cache_disable == $past(aux_wdata[0]));

    assert_status_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        aux_addr == REG_CTRL && aux_rdata[CTRL_STAT_BIT] |-> !aux_ready);

    assert_status_during_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && aux_addr == REG_CTRL |-> aux_rdata[CTRL_STAT_BIT]);
endmodule

bind dcache_maint dcache_maint_chk #(.SETS(SETS), .WAYS(WAYS), .LINE_BYTES(LINE_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_we(aux_we),
    .aux_ready(aux_ready), .aux_rdata(aux_rdata), .cache_disable(cache_disable),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_dirty(lk_dirty),
    .wb_req(wb_req), .wb_idx(wb_idx), .wb_way(wb_way), .wb_tag(wb_tag), .wb_ack(wb_ack)
);

// File: tb/dcache_maint_tb.sv
module dcache_maint_tb;
    localparam logic [11:0] A_INV_ALL = 12'h047, A_CTRL = 12'h048, A_INV_LN = 12'h04A;
    localparam logic [11:0] A_FL_ALL = 12'h04B, A_FL_LN = 12'h04C, A_PTAG = 12'h05C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] aux_addr = '0;
    logic [31:0] aux_wdata = '0;
    logic        aux_we = 1'b0;
    logic        aux_ready;
    logic [31:0] aux_rdata;
    logic        cache_disable;
    logic        fill_en = 1'b0;
    logic [2:0]  fill_idx = '0;
    logic [1:0]  fill_way = '0;
    logic [23:0] fill_tag = '0;
    logic        fill_dirty = 1'b0;
    logic [2:0]  lk_idx = '0;
    logic [23:0] lk_tag = '0;
    logic        lk_hit, lk_dirty;
    logic        wb_req;
    logic [2:0]  wb_idx;
    logic [1:0]  wb_way;
    logic [23:0] wb_tag;
    logic        wb_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int ack_cnt = 0;
    int log_n = 0;
    logic [2:0]  log_idx [64];
    logic [1:0]  log_way [64];
    logic [23:0] log_tag [64];

    always #5 clk = ~clk;

    dcache_maint u_dut (
        .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_we(aux_we),
        .aux_ready(aux_ready), .aux_rdata(aux_rdata), .cache_disable(cache_disable),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_way(fill_way), .fill_tag(fill_tag),
        .fill_dirty(fill_dirty), .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_hit(lk_hit),
        .lk_dirty(lk_dirty), .wb_req(wb_req), .wb_idx(wb_idx), .wb_way(wb_way),
        .wb_tag(wb_tag), .wb_ack(wb_ack)
    );

    // write-back responder: acknowledges on the third falling edge of a request
    always @(negedge clk) begin
        if (!rst_n) begin
            wb_ack = 1'b0;
            ack_cnt = 0;
        end else if (wb_ack) begin
            wb_ack = 1'b0;
        end else if (wb_req) begin
            ack_cnt++;
            if (ack_cnt == 3) begin
                if (log_n < 64) begin
                    log_idx[log_n] = wb_idx;
                    log_way[log_n] = wb_way;
                    log_tag[log_n] = wb_tag;
                end
                log_n++;
                wb_ack = 1'b1;
                ack_cnt = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic aux_write(input logic [11:0] a, input logic [31:0] d);
        while (!aux_ready) @(negedge clk);
        aux_addr = a; aux_wdata = d; aux_we = 1'b1;
        @(negedge clk);
        aux_we = 1'b0; aux_addr = '0; aux_wdata = '0;
    endtask

    task automatic aux_read(input logic [11:0] a, output logic [31:0] v);
        aux_addr = a;
        #1 v = aux_rdata;
        aux_addr = '0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (!aux_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(aux_ready, req, {63'd0, aux_ready}, 64'd1);
    endtask

    task automatic fill(input logic [2:0] s, input logic [1:0] w, input logic [23:0] t, input logic d);
        fill_en = 1'b1; fill_idx = s; fill_way = w; fill_tag = t; fill_dirty = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic look(input logic [2:0] s, input logic [23:0] t, input logic eh,
                        input logic ed, input string req);
        lk_idx = s; lk_tag = t;
        #1;
        chk(lk_hit == eh && lk_dirty == ed, req, {62'd0, lk_hit, lk_dirty}, {62'd0, eh, ed});
    endtask

    task automatic expect_wb(input int k, input logic [2:0] s, input logic [1:0] w,
                             input logic [23:0] t, input string req);
        chk(log_n > k && log_idx[k] == s && log_way[k] == w && log_tag[k] == t, req,
            {35'd0, log_idx[k], log_way[k], log_tag[k]}, {35'd0, s, w, t});
    endtask

    task automatic clean_slate();
        aux_write(A_CTRL, 32'h0);
        aux_write(A_INV_ALL, 32'h1);
        wait_idle("R4");
        log_n = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk(aux_ready == 1'b1, "R10", {63'd0, aux_ready}, 64'd1);
        chk(cache_disable == 1'b0, "R2", {63'd0, cache_disable}, 64'd0);
        chk(wb_req == 1'b0, "R11", {63'd0, wb_req}, 64'd0);
        aux_read(A_CTRL, v);
        chk(v == 32'h0, "R2", {32'd0, v}, 64'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        aux_write(A_CTRL, 32'h41);
        aux_read(A_CTRL, v);
        chk(v == 32'h41, "R2", {32'd0, v}, 64'h41);
        chk(cache_disable == 1'b1, "R2", {63'd0, cache_disable}, 64'd1);
        aux_write(A_CTRL, 32'h140);
        aux_read(A_CTRL, v);
        chk(v == 32'h40, "R9", {32'd0, v}, 64'h40);
        aux_write(A_PTAG, {24'hC0FFEE, 8'h5A});
        aux_read(A_PTAG, v);
        chk(v == {24'hC0FFEE, 8'h00}, "R1", {32'd0, v}, {32'd0, 24'hC0FFEE, 8'h00});
        aux_read(A_FL_LN, v);
        chk(v == 32'h0, "R1", {32'd0, v}, 64'd0);
        aux_write(A_CTRL, 32'h0);
    endtask

    task automatic t_flush_all();
        logic [31:0] v;
        clean_slate();
        fill(3'd1, 2'd2, 24'hA1A1A1, 1'b1);
        fill(3'd1, 2'd0, 24'hB2B2B2, 1'b0);
        fill(3'd5, 2'd3, 24'hC3C3C3, 1'b1);
        fill(3'd0, 2'd1, 24'hD4D4D4, 1'b1);
        aux_write(A_FL_ALL, 32'h1);
        aux_read(A_CTRL, v);
        chk(v[8] == 1'b1, "R9", {63'd0, v[8]}, 64'd1);
        wait_idle("R3");
        aux_read(A_CTRL, v);
        chk(v[8] == 1'b0, "R9", {63'd0, v[8]}, 64'd0);
        chk(log_n == 3, "R3", log_n, 64'd3);
        expect_wb(0, 3'd0, 2'd1, 24'hD4D4D4, "R3");
        expect_wb(1, 3'd1, 2'd2, 24'hA1A1A1, "R3");
        expect_wb(2, 3'd5, 2'd3, 24'hC3C3C3, "R3");
        look(3'd1, 24'hA1A1A1, 1'b1, 1'b0, "R3");
        look(3'd1, 24'hB2B2B2, 1'b1, 1'b0, "R3");
        look(3'd5, 24'hC3C3C3, 1'b1, 1'b0, "R3");
    endtask

    task automatic t_inv_discard();
        logic [31:0] v;
        clean_slate();
        fill(3'd2, 2'd0, 24'h111111, 1'b1);
        fill(3'd7, 2'd3, 24'h222222, 1'b1);
        fill(3'd4, 2'd1, 24'h333333, 1'b0);
        aux_write(A_INV_ALL, 32'h1);
        chk(aux_ready == 1'b0, "R10", {63'd0, aux_ready}, 64'd0);
        aux_read(A_CTRL, v);
        chk(v[8] == 1'b0, "R9", {63'd0, v[8]}, 64'd0);
        wait_idle("R4");
        chk(log_n == 0, "R4", log_n, 64'd0);
        look(3'd2, 24'h111111, 1'b0, 1'b0, "R4");
        look(3'd7, 24'h222222, 1'b0, 1'b0, "R4");
        look(3'd4, 24'h333333, 1'b0, 1'b0, "R4");
    endtask

    task automatic t_inv_wb();
        clean_slate();
        fill(3'd2, 2'd0, 24'hE0E0E0, 1'b1);
        fill(3'd7, 2'd3, 24'hF0F0F0, 1'b1);
        fill(3'd3, 2'd1, 24'h5A5A5A, 1'b0);
        aux_write(A_CTRL, 32'h40);
        aux_write(A_INV_ALL, 32'h1);
        wait_idle("R5");
        chk(log_n == 2, "R5", log_n, 64'd2);
        expect_wb(0, 3'd2, 2'd0, 24'hE0E0E0, "R5");
        expect_wb(1, 3'd7, 2'd3, 24'hF0F0F0, "R5");
        look(3'd2, 24'hE0E0E0, 1'b0, 1'b0, "R5");
        look(3'd7, 24'hF0F0F0, 1'b0, 1'b0, "R5");
        look(3'd3, 24'h5A5A5A, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_bit0_clear();
        clean_slate();
        fill(3'd6, 2'd2, 24'h777777, 1'b1);
        aux_write(A_FL_ALL, 32'h2);
        chk(aux_ready == 1'b1, "R13", {63'd0, aux_ready}, 64'd1);
        aux_write(A_INV_ALL, 32'h0);
        chk(aux_ready == 1'b1, "R13", {63'd0, aux_ready}, 64'd1);
        repeat (3) @(negedge clk);
        chk(log_n == 0, "R13", log_n, 64'd0);
        look(3'd6, 24'h777777, 1'b1, 1'b1, "R13");
    endtask

    task automatic t_line_flush();
        clean_slate();
        fill(3'd4, 2'd2, 24'h404040, 1'b1);
        fill(3'd4, 2'd1, 24'h414141, 1'b1);
        aux_write(A_PTAG, {24'h404040, 8'hFF});
        aux_write(A_FL_LN, {24'h9C1234, 3'd4, 5'h13});
        @(negedge clk);
        look(3'd4, 24'h404040, 1'b1, 1'b1, "R11");
        chk(wb_req && wb_idx == 3'd4 && wb_way == 2'd2, "R11",
            {59'd0, wb_req, wb_idx, wb_way}, {59'd0, 1'b1, 3'd4, 2'd2});
        wait_idle("R6");
        chk(log_n == 1, "R6", log_n, 64'd1);
        expect_wb(0, 3'd4, 2'd2, 24'h404040, "R6");
        look(3'd4, 24'h404040, 1'b1, 1'b0, "R6");
        look(3'd4, 24'h414141, 1'b1, 1'b1, "R6");
        aux_write(A_PTAG, {24'h414141, 8'h00});
        aux_write(A_FL_LN, {24'h000000, 3'd4, 5'h1F});
        wait_idle("R12");
        chk(log_n == 2, "R12", log_n, 64'd2);
        expect_wb(1, 3'd4, 2'd1, 24'h414141, "R12");
        aux_write(A_INV_LN, {24'h123456, 3'd4, 5'h07});
        wait_idle("R12");
        chk(log_n == 2, "R12", log_n, 64'd2);
        look(3'd4, 24'h414141, 1'b0, 1'b0, "R12");
        look(3'd4, 24'h404040, 1'b1, 1'b0, "R12");
    endtask

    task automatic t_line_inv();
        clean_slate();
        fill(3'd6, 2'd0, 24'h6A6A6A, 1'b1);
        fill(3'd6, 2'd3, 24'h6B6B6B, 1'b1);
        aux_write(A_CTRL, 32'h40);
        aux_write(A_PTAG, {24'h6A6A6A, 8'h00});
        aux_write(A_INV_LN, {24'h0, 3'd6, 5'h00});
        wait_idle("R7");
        chk(log_n == 1, "R7", log_n, 64'd1);
        expect_wb(0, 3'd6, 2'd0, 24'h6A6A6A, "R7");
        look(3'd6, 24'h6A6A6A, 1'b0, 1'b0, "R7");
        aux_write(A_CTRL, 32'h0);
        aux_write(A_PTAG, {24'h6B6B6B, 8'h00});
        aux_write(A_INV_LN, {24'h0, 3'd6, 5'h04});
        wait_idle("R7");
        chk(log_n == 1, "R7", log_n, 64'd1);
        look(3'd6, 24'h6B6B6B, 1'b0, 1'b0, "R7");
    endtask

    task automatic t_no_match();
        clean_slate();
        fill(3'd3, 2'd2, 24'h3C3C3C, 1'b1);
        aux_write(A_PTAG, {24'h3C3C3D, 8'h00});
        aux_write(A_FL_LN, {24'h0, 3'd3, 5'h00});
        chk(aux_ready == 1'b0, "R8", {63'd0, aux_ready}, 64'd0);
        @(negedge clk);
        chk(aux_ready == 1'b1, "R8", {63'd0, aux_ready}, 64'd1);
        repeat (4) @(negedge clk);
        chk(log_n == 0, "R8", log_n, 64'd0);
        look(3'd3, 24'h3C3C3C, 1'b1, 1'b1, "R8");
    endtask

    task automatic t_hold_off();
        logic [31:0] v;
        clean_slate();
        fill(3'd0, 2'd0, 24'hAAAA01, 1'b1);
        fill(3'd1, 2'd3, 24'hAAAA02, 1'b1);
        aux_write(A_FL_ALL, 32'h1);
        chk(aux_ready == 1'b0, "R10", {63'd0, aux_ready}, 64'd0);
        aux_addr = A_CTRL; aux_wdata = 32'h41; aux_we = 1'b1;
        @(negedge clk);
        aux_we = 1'b0; aux_addr = '0; aux_wdata = '0;
        wait_idle("R10");
        aux_read(A_CTRL, v);
        chk(v == 32'h0, "R10", {32'd0, v}, 64'd0);
        chk(cache_disable == 1'b0, "R10", {63'd0, cache_disable}, 64'd0);
        chk(log_n == 2, "R10", log_n, 64'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_flush_all();
        t_inv_discard();
        t_inv_wb();
        t_bit0_clear();
        t_line_flush();
        t_line_inv();
        t_no_match();
        t_hold_off();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule